// File: doc/BRIEF.md
# Atomic Memory Operation Unit

This unit performs one read-modify-write on a single-port synchronous memory for each request it accepts from an execute stage. Each request carries a base register value, a signed 16-bit displacement, an access size, an operation immediate, the source register value and the R0 value. The unit locks the memory, reads the old value and computes the new one. It writes the new value back when the operation calls for it, then returns the source and R0 register updates, each with its own write-enable.

The operations are add, or, and, xor, exchange and compare-exchange. The four simple operations can also return the old memory value. Word (32-bit) and double-word (64-bit) accesses are supported. Any other size, or any immediate outside the legal set, gets an error response without a memory access. Only one operation is in flight at a time, and no other access can slip in between the unit's read and its write.

Top module: `amo_unit`

## Requirements
- R1: `req_ready_o` is high only when the unit is idle. Each accepted request gives exactly one `rsp_valid_o` pulse, and responses come in request order. A legal request responds 5 cycles after the accepting edge (4 for a compare-exchange that does not match). An error response comes 1 cycle after the accepting edge.
- R2: Size codes are `req_size_i` 0 = word, 1 = half, 2 = byte, 3 = double word. Half and byte get an error response (`rsp_err_o`=1) with both write-enables low, and cause no memory access.
- R3: The legal 32-bit immediates are 0x00 add, 0x40 or, 0x50 and, 0xa0 xor, each optionally ORed with 0x01 (fetch), plus 0xe1 exchange and 0xf1 compare-exchange. Any other value gets an error response and causes no memory access.
- R4: The memory address is `req_base_i` plus the sign-extended `req_offset_i`.
- R5: Add, or and and xor store old op src in memory, wrapping at the access width. A word operation uses only the low 32 bits of the operands and memory.
- R6: With the fetch bit (0x01) set, a simple operation returns the old memory value on `rsp_src_o` with `rsp_src_we_o`=1. Without it, both write-enables stay low.
- R7: Exchange stores the source value and returns the old memory value on `rsp_src_o` with `rsp_src_we_o`=1.
- R8: Compare-exchange stores the source value only when the old memory value equals R0. In both outcomes it returns the old value on `rsp_r0_o` with `rsp_r0_we_o`=1 and `rsp_src_we_o`=0.
- R9: Every memory access happens while `mem_lock_o` is high. The lock stays high without a break from the read through the response. A legal operation performs exactly one read and at most one write.
- R10: Values returned to registers are zero-extended. A word compare-exchange compares only the low 32 bits of R0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Unit can accept a request |
| req_base_i | input | 64 | Base register value |
| req_offset_i | input | 16 | Signed displacement |
| req_size_i | input | 2 | Access size code |
| req_imm_i | input | 32 | Operation immediate |
| req_src_i | input | 64 | Source register value |
| req_r0_i | input | 64 | R0 value |
| rsp_valid_o | output | 1 | Response valid, one cycle |
| rsp_err_o | output | 1 | Unsupported size or immediate |
| rsp_src_we_o | output | 1 | Write source register |
| rsp_src_o | output | 64 | New source register value |
| rsp_r0_we_o | output | 1 | Write R0 |
| rsp_r0_o | output | 64 | New R0 value |
| mem_lock_o | output | 1 | Memory locked by the unit |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Access is a write |
| mem_dword_o | output | 1 | Access is 64-bit (else 32-bit) |
| mem_addr_o | output | 64 | Byte address |
| mem_wdata_o | output | 64 | Write data |
| mem_rdata_i | input | 64 | Read data, valid the cycle after a read strobe |

## Verification
A new request and the response to the previous one can fall in the same cycle. The bench provokes this by issuing its requests back to back and holding `req_valid_i` high while a response is going out. The scoreboard then checks that the held request is accepted only after the response. It also checks that each response carries the fields of its own operation and arrives at its exact latency. A second case is the compare-exchange mismatch, where the skipped write shortens the operation. There the bench checks the shorter latency, the unchanged memory, and the final totals of reads and writes.

// File: rtl/amo_pkg.sv
package amo_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOCK, ST_READ, ST_MODIFY, ST_WRITE, ST_RESPOND
  } amo_state_e;

  typedef enum logic [2:0] {
    OP_ADD, OP_OR, OP_AND, OP_XOR, OP_XCHG, OP_CMPXCHG
  } amo_op_e;

  typedef struct packed {
    logic    legal;
    amo_op_e op;
    logic    ret_src;
    logic    ret_r0;
  } amo_dec_t;

  localparam logic [1:0] SZ_WORD  = 2'd0;
  localparam logic [1:0] SZ_DWORD = 2'd3;
endpackage

// File: rtl/amo_decode.sv
module amo_decode
  import amo_pkg::*;
#(
  parameter int IMM_W = 32
) (
  input  logic [IMM_W-1:0] imm_i,
  output amo_dec_t         dec_o
);
  logic hi_zero;
  assign hi_zero = (imm_i[IMM_W-1:8] == '0);

  always_comb begin
    dec_o = '{legal: 1'b1, op: OP_ADD, ret_src: imm_i[0], ret_r0: 1'b0};
    unique case (imm_i[7:0])
      8'h00, 8'h01: dec_o.op = OP_ADD;
      8'h40, 8'h41: dec_o.op = OP_OR;
      8'h50, 8'h51: dec_o.op = OP_AND;
      8'ha0, 8'ha1: dec_o.op = OP_XOR;
      8'he1:        dec_o.op = OP_XCHG;
      8'hf1: begin
        dec_o.op      = OP_CMPXCHG;
        dec_o.ret_src = 1'b0;
        dec_o.ret_r0  = 1'b1;
      end
      default:      dec_o.legal = 1'b0;
    endcase
    if (!hi_zero) dec_o.legal = 1'b0;
  end
endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  amo_op_e         op_i,
  input  logic            dword_i,
  input  logic [XLEN-1:0] rdata_i,
  input  logic [XLEN-1:0] src_i,
  input  logic [XLEN-1:0] r0_i,
  output logic [XLEN-1:0] old_o,
  output logic [XLEN-1:0] new_o,
  output logic            wr_o
);
  localparam int HW = XLEN / 2;

  logic [XLEN-1:0] s_op, r_op, res;

  // narrow operands are zero-extended so upper halves never matter
  assign old_o = dword_i ? rdata_i : {{HW{1'b0}}, rdata_i[HW-1:0]};
  assign s_op  = dword_i ? src_i   : {{HW{1'b0}}, src_i[HW-1:0]};
  assign r_op  = dword_i ? r0_i    : {{HW{1'b0}}, r0_i[HW-1:0]};

  always_comb begin
    unique case (op_i)
      OP_ADD:  res = old_o + s_op;
      OP_OR:   res = old_o | s_op;
      OP_AND:  res = old_o & s_op;
      OP_XOR:  res = old_o ^ s_op;
      default: res = s_op;
    endcase
  end

  assign new_o = dword_i ? res : {{HW{1'b0}}, res[HW-1:0]};
  assign wr_o  = (op_i != OP_CMPXCHG) || (old_o == r_op);
endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int ADDR_W = 64,
  parameter int OFF_W  = 16,
  parameter int IMM_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_base_i,
  input  logic [OFF_W-1:0]  req_offset_i,
  input  logic [1:0]        req_size_i,
  input  logic [IMM_W-1:0]  req_imm_i,
  input  logic [XLEN-1:0]   req_src_i,
  input  logic [XLEN-1:0]   req_r0_i,
  output logic              rsp_valid_o,
  output logic              rsp_err_o,
  output logic              rsp_src_we_o,
  output logic [XLEN-1:0]   rsp_src_o,
  output logic              rsp_r0_we_o,
  output logic [XLEN-1:0]   rsp_r0_o,
  output logic              mem_lock_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic              mem_dword_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [XLEN-1:0]   mem_wdata_o,
  input  logic [XLEN-1:0]   mem_rdata_i
);
  localparam int EXT_W = ADDR_W - OFF_W;

  amo_state_e        state_q;
  amo_dec_t          dec_d, dec_q;
  logic              err_q, dword_q, wr_q, alu_wr;
  logic [ADDR_W-1:0] base_q, addr_q;
  logic [OFF_W-1:0]  off_q;
  logic [XLEN-1:0]   src_q, r0_q, old_q, new_q, alu_old, alu_new;

  amo_decode #(.IMM_W(IMM_W)) u_dec (
    .imm_i (req_imm_i),
    .dec_o (dec_d)
  );

  amo_alu #(.XLEN(XLEN)) u_alu (
    .op_i    (dec_q.op),
    .dword_i (dword_q),
    .rdata_i (mem_rdata_i),
    .src_i   (src_q),
    .r0_i    (r0_q),
    .old_o   (alu_old),
    .new_o   (alu_new),
    .wr_o    (alu_wr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dec_q   <= '0;
      err_q   <= 1'b0;
      dword_q <= 1'b0;
      wr_q    <= 1'b0;
      base_q  <= '0;
      off_q   <= '0;
      addr_q  <= '0;
      src_q   <= '0;
      r0_q    <= '0;
      old_q   <= '0;
      new_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          dec_q   <= dec_d;
          dword_q <= (req_size_i == SZ_DWORD);
          err_q   <= !dec_d.legal ||
                     !(req_size_i == SZ_WORD || req_size_i == SZ_DWORD);
          base_q  <= req_base_i;
          off_q   <= req_offset_i;
          src_q   <= req_src_i;
          r0_q    <= req_r0_i;
          state_q <= (dec_d.legal &&
                      (req_size_i == SZ_WORD || req_size_i == SZ_DWORD))
                     ? ST_LOCK : ST_RESPOND;
        end
        ST_LOCK: begin
          // address add kept off the request path
          addr_q  <= base_q + {{EXT_W{off_q[OFF_W-1]}}, off_q};
          state_q <= ST_READ;
        end
        ST_READ:   state_q <= ST_MODIFY;
        ST_MODIFY: begin
          old_q   <= alu_old;
          new_q   <= alu_new;
          wr_q    <= alu_wr;
          state_q <= alu_wr ? ST_WRITE : ST_RESPOND;
        end
        ST_WRITE:   state_q <= ST_RESPOND;
        ST_RESPOND: state_q <= ST_IDLE;
        default:    state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o  = (state_q == ST_IDLE);
  assign mem_lock_o   = !err_q && (state_q inside {ST_READ, ST_MODIFY, ST_WRITE, ST_RESPOND});
  assign mem_req_o    = (state_q == ST_READ) || (state_q == ST_WRITE && wr_q);
  assign mem_we_o     = (state_q == ST_WRITE);
  assign mem_dword_o  = dword_q;
  assign mem_addr_o   = addr_q;
  assign mem_wdata_o  = new_q;

  assign rsp_valid_o  = (state_q == ST_RESPOND);
  assign rsp_err_o    = rsp_valid_o && err_q;
  assign rsp_src_we_o = rsp_valid_o && !err_q && dec_q.ret_src;
  assign rsp_r0_we_o  = rsp_valid_o && !err_q && dec_q.ret_r0;
  assign rsp_src_o    = old_q;
  assign rsp_r0_o     = old_q;
endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_ready_o,
  input logic        rsp_valid_o,
  input logic        rsp_err_o,
  input logic        rsp_src_we_o,
  input logic        rsp_r0_we_o,
  input logic        mem_lock_o,
  input logic        mem_req_o,
  input logic [63:0] mem_addr_o
);
  AST_RSP_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o); // R1
  AST_ERR_NO_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_err_o) |-> (!rsp_src_we_o && !rsp_r0_we_o)); // R2
  AST_WE_IN_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_src_we_o || rsp_r0_we_o) |-> rsp_valid_o); // R6
  AST_ONE_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !(rsp_src_we_o && rsp_r0_we_o)); // R8
  AST_MEM_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_lock_o); // R9
  AST_LOCK_TO_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_lock_o) |-> $past(rsp_valid_o)); // R9
  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_lock_o && $past(mem_lock_o)) |-> $stable(mem_addr_o)); // R4
endmodule

bind amo_unit amo_unit_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_ready_o  (req_ready_o),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_err_o    (rsp_err_o),
  .rsp_src_we_o (rsp_src_we_o),
  .rsp_r0_we_o  (rsp_r0_we_o),
  .mem_lock_o   (mem_lock_o),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o)
);

// File: tb/amo_unit_tb.sv
module amo_unit_tb;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_ready_o;
  logic [63:0] req_base_i = '0, req_src_i = '0, req_r0_i = '0;
  logic [15:0] req_offset_i = '0;
  logic [1:0]  req_size_i = '0;
  logic [31:0] req_imm_i = '0;
  logic        rsp_valid_o, rsp_err_o, rsp_src_we_o, rsp_r0_we_o;
  logic [63:0] rsp_src_o, rsp_r0_o;
  logic        mem_lock_o, mem_req_o, mem_we_o, mem_dword_o;
  logic [63:0] mem_addr_o, mem_wdata_o, mem_rdata_i = '0;

  always #4 clk = ~clk;

  amo_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_base_i(req_base_i), .req_offset_i(req_offset_i), .req_size_i(req_size_i),
    .req_imm_i(req_imm_i), .req_src_i(req_src_i), .req_r0_i(req_r0_i),
    .rsp_valid_o(rsp_valid_o), .rsp_err_o(rsp_err_o),
    .rsp_src_we_o(rsp_src_we_o), .rsp_src_o(rsp_src_o),
    .rsp_r0_we_o(rsp_r0_we_o), .rsp_r0_o(rsp_r0_o),
    .mem_lock_o(mem_lock_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_dword_o(mem_dword_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
  );

  int checks = 0, errors = 0, cyc = 0;
  int n_rd = 0, n_wr = 0, n_unlocked = 0, exp_rd = 0, exp_wr = 0;
  logic [7:0] mem [256];
  logic [7:0] ref_mem [256];

  typedef struct {
    string       tag;
    logic        err, swe, rwe;
    logic [63:0] sv, rv;
    int          lat, acc;
  } exp_t;
  exp_t q[$];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // memory model: read data registered, little-endian bytes
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req_o) begin
      if (!mem_lock_o) n_unlocked++;
      if (mem_we_o) begin
        n_wr++;
        for (int b = 0; b < 8; b++)
          if (b < 4 || mem_dword_o) mem[(mem_addr_o[7:0] + b) % 256] <= mem_wdata_o[8*b +: 8];
      end else begin
        n_rd++;
        for (int b = 0; b < 8; b++)
          mem_rdata_i[8*b +: 8] <= (b < 4 || mem_dword_o) ? mem[(mem_addr_o[7:0] + b) % 256] : 8'h00;
      end
    end
  end

  function automatic logic [63:0] ref_rd(input int a, input bit dw);
    logic [63:0] v = '0;
    for (int b = 0; b < 8; b++) if (b < 4 || dw) v[8*b +: 8] = ref_mem[(a + b) % 256];
    return v;
  endfunction

  // reference model, built from the requirement text
  task automatic issue(input string tag, input logic [63:0] base, input logic [15:0] off,
                       input logic [1:0] size, input logic [31:0] imm,
                       input logic [63:0] src, input logic [63:0] r0);
    exp_t e;
    logic [63:0] old, s, r, nv, m;
    int a;
    bit dw, legal, wr, fetch;
    e.tag = tag; e.swe = 0; e.rwe = 0; e.sv = '0; e.rv = '0;
    dw    = (size == 2'd3);
    m     = dw ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    legal = (imm inside {32'h00, 32'h01, 32'h40, 32'h41, 32'h50, 32'h51,
                         32'ha0, 32'ha1, 32'he1, 32'hf1}) && (size == 2'd0 || size == 2'd3);
    e.err = !legal;
    e.lat = 1;
    if (legal) begin
      a   = int'((base + {{48{off[15]}}, off}) & 64'hFF);
      old = ref_rd(a, dw);
      s   = src & m; r = r0 & m;
      fetch = imm[0];
      wr  = 1;
      case (imm[7:4])
        4'h0: nv = old + s;
        4'h4: nv = old | s;
        4'h5: nv = old & s;
        4'ha: nv = old ^ s;
        4'he: nv = s;
        default: begin nv = s; wr = (old == r); fetch = 0; e.rwe = 1; e.rv = old; end
      endcase
      nv &= m;
      if (fetch) begin e.swe = 1; e.sv = old; end
      if (wr) for (int b = 0; b < 8; b++) if (b < 4 || dw) ref_mem[(a + b) % 256] = nv[8*b +: 8];
      exp_rd++;
      if (wr) exp_wr++;
      e.lat = wr ? 5 : 4;
    end
    req_base_i = base; req_offset_i = off; req_size_i = size;
    req_imm_i = imm; req_src_i = src; req_r0_i = r0; req_valid_i = 1'b1;
    while (!req_ready_o) @(negedge clk);
    e.acc = cyc;
    q.push_back(e);
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  // monitor: pops and compares each response
  always @(negedge clk) begin
    if (rst_ni && rsp_valid_o) begin
      exp_t e;
      if (q.size() == 0) check(0, "R1 unexpected response", 64'd1, 64'd0);
      else begin
        e = q.pop_front();
        check(cyc - e.acc == e.lat, {e.tag, " R1 latency"}, 64'(cyc - e.acc), 64'(e.lat));
        check(rsp_err_o == e.err, {e.tag, " R2 R3 err"}, 64'(rsp_err_o), 64'(e.err));
        check(rsp_src_we_o == e.swe, {e.tag, " R6 R7 src_we"}, 64'(rsp_src_we_o), 64'(e.swe));
        check(rsp_r0_we_o == e.rwe, {e.tag, " R8 r0_we"}, 64'(rsp_r0_we_o), 64'(e.rwe));
        if (e.swe) check(rsp_src_o == e.sv, {e.tag, " R6 R7 src"}, rsp_src_o, e.sv);
        if (e.rwe) check(rsp_r0_o == e.rv, {e.tag, " R8 R10 r0"}, rsp_r0_o, e.rv);
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "watchdog", 64'(cyc), 64'd0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = 8'(i * 7 + 3); ref_mem[i] = 8'(i * 7 + 3); end
    repeat (3) @(negedge clk);
    check(req_ready_o == 1 && rsp_valid_o == 0 && mem_lock_o == 0, "R1 reset state",
          {req_ready_o, rsp_valid_o, mem_lock_o}, 64'd4);
    rst_ni = 1'b1;
    @(negedge clk);
    check(req_ready_o == 1, "R1 idle ready", 64'(req_ready_o), 64'd1);
    // back-to-back requests: each is held while the previous responds
    issue("R5 add dw",           64'h40, 16'h0, 2'd3, 32'h00, 64'h5, 64'h0);
    issue("R7 xchg w",           64'h48, 16'h0, 2'd0, 32'he1, 64'hDEAD_0000_FFFF_FFFF, 64'h0);
    issue("R5 R6 add fetch wrap", 64'h48, 16'h0, 2'd0, 32'h01, 64'h1_0000_0002, 64'h0);
    issue("R4 or fetch neg off", 64'h58, 16'hFFF8, 2'd3, 32'h41, 64'hF0F0_0000_0000_000F, 64'h0);
    issue("R6 and w no fetch",   64'h60, 16'h0, 2'd0, 32'h50, 64'h0000_0000_00FF_00FF, 64'h0);
    issue("R4 xor fetch pos off", 64'h60, 16'h10, 2'd3, 32'ha1, 64'h0123_4567_89AB_CDEF, 64'h0);
    issue("R7 xchg dw",          64'h80, 16'h0, 2'd3, 32'he1, 64'h1122_3344_5566_7788, 64'h0);
    issue("R8 cmpxchg match",    64'h80, 16'h0, 2'd3, 32'hf1, 64'hAA, 64'h1122_3344_5566_7788);
    issue("R8 cmpxchg miss",     64'h80, 16'h0, 2'd3, 32'hf1, 64'hBB, 64'h0);
    issue("R7 xchg w2",          64'h90, 16'h0, 2'd0, 32'he1, 64'hCAFE_BABE, 64'h0);
    issue("R10 cmpxchg w",       64'h90, 16'h0, 2'd0, 32'hf1, 64'h1234_5678, 64'hFFFF_FFFF_CAFE_BABE);
    issue("R2 byte size",        64'h40, 16'h0, 2'd2, 32'h01, 64'h1, 64'h0);
    issue("R2 half size",        64'h40, 16'h0, 2'd1, 32'he1, 64'h1, 64'h0);
    issue("R3 imm 02",           64'h40, 16'h0, 2'd3, 32'h02, 64'h1, 64'h0);
    issue("R3 imm e0",           64'h40, 16'h0, 2'd3, 32'he0, 64'h1, 64'h0);
    issue("R3 imm f0",           64'h40, 16'h0, 2'd0, 32'hf0, 64'h1, 64'h0);
    issue("R3 imm 100",          64'h40, 16'h0, 2'd3, 32'h100, 64'h1, 64'h0);
    issue("R5 add w after err",  64'h48, 16'h0, 2'd0, 32'h01, 64'h3, 64'h0);
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 256; i++)
      if (mem[i] !== ref_mem[i]) check(0, $sformatf("R4 R5 mem[%0d]", i), 64'(mem[i]), 64'(ref_mem[i]));
    check(1, "R4 R5 memory image", 64'd0, 64'd0);
    check(n_rd == exp_rd, "R9 R2 R3 read count", 64'(n_rd), 64'(exp_rd));
    check(n_wr == exp_wr, "R9 R8 write count", 64'(n_wr), 64'(exp_wr));
    check(n_unlocked == 0, "R9 unlocked accesses", 64'(n_unlocked), 64'd0);
    check(mem_lock_o == 0, "R9 lock released", 64'(mem_lock_o), 64'd0);
    finish_run();
  end
endmodule